// File: doc/BRIEF.md
# Translation Buffer with Global and Big-Page Entries

This block is a small fully associative translation buffer for a 32-bit paging unit. A lookup presents a virtual address and, in the same cycle, gets back a hit or miss indication and the physical address. The low bits of the virtual address are the offset inside the page and pass through unchanged. The upper bits are the key that is compared against every entry. A miss tells the surrounding logic to start a table walk. The result of that walk is written back through the fill port.

Each entry maps either a 4 KiB page or a 4 MiB big page. It carries a global marker and records whether it has been used (accessed) and written (dirty). Two flush commands exist. The normal one, used on a process switch, removes only the entries that are not global, so mappings shared by all processes survive. The full one empties the buffer. A fill goes to the lowest-numbered free slot. When no slot is free, a round-robin pointer picks the slot to overwrite. A fill first removes any entry whose region overlaps the new one, so no address can ever match two entries.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no entry is valid, and every lookup reports a miss.
- R2: A small-page hit returns a physical address made of the entry's 20-bit frame number followed by virtual address bits 11:0. The result appears combinationally in the same cycle as the lookup.
- R3: A big-page entry compares only virtual address bits 31:22 against bits 19:10 of its stored page number. On a hit it returns frame bits 19:10 followed by virtual address bits 21:0.
- R4: With the lookup request high, exactly one of hit and miss is high. With the request low, both are low.
- R5: The lookup also reports the matched entry's stored accessed and dirty flags, as they were before the current lookup. Any hit sets accessed at the next edge. Only a write hit (write input 1) sets dirty.
- R6: A normal flush invalidates every entry whose global flag is 0 and leaves entries with the global flag 1 valid.
- R7: A full flush invalidates every entry, global ones included.
- R8: A flush of either kind takes priority over a fill in the same cycle, and that fill is discarded.
- R9: A fill writes the lowest-numbered free entry. When all entries are valid, it writes the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such fill.
- R10: Before it writes, a fill invalidates every valid entry that overlaps the new mapping: same 20-bit page number when both are small, or same bits 19:10 when either is big. A refill therefore replaces an older translation, and at most one entry matches any address.
- R11: A fill becomes visible to lookups only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | A valid entry matches |
| lk_miss | output | 1 | No entry matches; start a table walk |
| lk_paddr | output | 32 | Translated physical address (0 on miss) |
| lk_accessed | output | 1 | Stored accessed flag of the matching entry |
| lk_dirty | output | 1 | Stored dirty flag of the matching entry |
| fill_en | input | 1 | Write a new translation |
| fill_vpn | input | 20 | Virtual page number of the new translation |
| fill_pfn | input | 20 | Frame number of the new translation |
| fill_big | input | 1 | New translation is a 4 MiB big page |
| fill_global | input | 1 | New translation survives a normal flush |
| flush_local | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with its default parameters: eight entries, 32-bit addresses, 12-bit small offsets and 22-bit big offsets. With only eight slots, eight fills take every free slot, so the ninth and tenth fills reach the round-robin path right after reset, while the pointer is still known to be zero. The 22-bit big offset lets the bench check both ends of a 4 MiB region, and the address just past it, against a single entry. It also lets the bench check how small and big pages replace each other when they overlap.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

  // Per-entry status bits kept beside the tag and frame storage.
  typedef struct packed {
    logic valid;
    logic big;
    logic glob;
    logic acc;
    logic dirty;
  } xbuf_flags_t;

  localparam xbuf_flags_t XBUF_FLAGS_EMPTY = '{valid: 1'b0, big: 1'b0, glob: 1'b0,
                                               acc: 1'b0, dirty: 1'b0};

endpackage

// File: rtl/xbuf_match.sv
// Compares one stored entry against a query page number. The compare is
// coarse (upper tag only) when either side describes a big page.
module xbuf_match #(
  parameter int VPN_W = 20,
  parameter int TAG_W = 10
) (
  input  logic             ent_valid,
  input  logic             ent_big,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic             q_big,
  output logic             hit
);
  localparam int LO = VPN_W - TAG_W;

  logic coarse_eq;
  logic fine_eq;

  always_comb begin
    coarse_eq = (ent_vpn[VPN_W-1:LO] == q_vpn[VPN_W-1:LO]);
    fine_eq   = (ent_vpn == q_vpn);
    hit       = ent_valid && ((ent_big || q_big) ? coarse_eq : fine_eq);
  end
endmodule

// File: rtl/xbuf_victim.sv
// Picks the slot a fill writes: lowest free slot, else round-robin pointer.
module xbuf_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] free_mask,
  input  logic               advance,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic             found;

  always_comb begin
    idx_o = rr_q;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (free_mask[i] && !found) begin
        idx_o = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (advance && !found) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R9: a fill into a full buffer moves the pointer on.
  p_rr_moves_r9: assert property (@(posedge clk) disable iff (rst)
    (advance && (free_mask == '0) && (ENTRIES > 1)) |=> (rr_q != $past(rr_q)));

  // R9: a fill with a free slot leaves the pointer alone.
  p_rr_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (advance && (free_mask != '0)) |=> $stable(rr_q));
endmodule

// File: rtl/xbuf_store.sv
// Entry storage: status flags with reset, tag/frame arrays without reset.
module xbuf_store
  import xbuf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush_local,
  input  logic               flush_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRIES-1:0] clr_mask,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               wr_big,
  input  logic               wr_glob,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic               touch_write,
  output xbuf_flags_t        flags_o [ENTRIES],
  output logic [VPN_W-1:0]   vpn_o   [ENTRIES],
  output logic [PFN_W-1:0]   pfn_o   [ENTRIES]
);
  xbuf_flags_t      flags_q [ENTRIES];
  logic [VPN_W-1:0] vpn_q   [ENTRIES];
  logic [PFN_W-1:0] pfn_q   [ENTRIES];
  logic             wr_fire;

  assign wr_fire = wr_en && !flush_local && !flush_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) flags_q[i] <= XBUF_FLAGS_EMPTY;
    end else begin
      if (touch_en) begin
        flags_q[touch_idx].acc <= 1'b1;
        if (touch_write) flags_q[touch_idx].dirty <= 1'b1;
      end
      if (flush_all) begin
        for (int i = 0; i < ENTRIES; i++) flags_q[i].valid <= 1'b0;
      end else if (flush_local) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (!flags_q[i].glob) flags_q[i].valid <= 1'b0;
        end
      end else if (wr_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (clr_mask[i]) flags_q[i].valid <= 1'b0;
        end
        flags_q[wr_idx] <= '{valid: 1'b1, big: wr_big, glob: wr_glob,
                             acc: 1'b0, dirty: 1'b0};
      end
    end
  end

  // Plain write-only arrays, no reset: storage can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      vpn_q[wr_idx] <= wr_vpn;
      pfn_q[wr_idx] <= wr_pfn;
    end
  end

  assign flags_o = flags_q;
  assign vpn_o   = vpn_q;
  assign pfn_o   = pfn_q;

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] glob_vec;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      valid_vec[i] = flags_q[i].valid;
      glob_vec[i]  = flags_q[i].glob;
    end
  end

  // R7: a full flush leaves nothing valid.
  p_flush_all_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_vec == '0));

  // R6: after a normal flush only global entries may remain.
  p_flush_local_global_r6: assert property (@(posedge clk) disable iff (rst)
    (flush_local && !flush_all) |=> ((valid_vec & ~glob_vec) == '0));

  // R8: a flush with a same-cycle fill adds no entry.
  p_flush_beats_fill_r8: assert property (@(posedge clk) disable iff (rst)
    ((flush_local || flush_all) && wr_en) |=> ($countones(valid_vec) <= $countones($past(valid_vec))));

  // R5: dirty is only ever set together with accessed.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    p_dirty_has_acc_r5: assert property (@(posedge clk) disable iff (rst)
      flags_q[g].dirty |-> flags_q[g].acc);
  end
endmodule

// File: rtl/xlat_buffer.sv
// Fully associative translation buffer, small and big pages, global entries.
module xlat_buffer
  import xbuf_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int SMALL_OFS = 12,
  parameter int BIG_OFS   = 22,
  parameter int ENTRIES   = 8,
  localparam int VPN_W     = VA_W - SMALL_OFS,
  localparam int PFN_W     = PA_W - SMALL_OFS,
  localparam int TAG_W     = VA_W - BIG_OFS,
  localparam int BIG_SHIFT = BIG_OFS - SMALL_OFS,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_accessed,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_big,
  input  logic             fill_global,
  input  logic             flush_local,
  input  logic             flush_all
);
  xbuf_flags_t        ent_flags [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn   [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] ov_match;
  logic [ENTRIES-1:0] free_mask;
  logic [VPN_W-1:0]   lk_vpn;
  logic [IDX_W-1:0]   vict_idx;
  logic [IDX_W-1:0]   sel_idx;
  logic [IDX_W-1:0]   small_idx;
  logic [IDX_W-1:0]   big_idx;
  logic               small_found;
  logic               big_found;
  logic               any_match;
  logic               fill_fire;

  assign lk_vpn    = lk_vaddr[VA_W-1:SMALL_OFS];
  assign fill_fire = fill_en && !flush_local && !flush_all;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xbuf_match #(.VPN_W(VPN_W), .TAG_W(TAG_W)) u_lk_match (
      .ent_valid (ent_flags[g].valid),
      .ent_big   (ent_flags[g].big),
      .ent_vpn   (ent_vpn[g]),
      .q_vpn     (lk_vpn),
      .q_big     (1'b0),
      .hit       (lk_match[g])
    );
    xbuf_match #(.VPN_W(VPN_W), .TAG_W(TAG_W)) u_ov_match (
      .ent_valid (ent_flags[g].valid),
      .ent_big   (ent_flags[g].big),
      .ent_vpn   (ent_vpn[g]),
      .q_vpn     (fill_vpn),
      .q_big     (fill_big),
      .hit       (ov_match[g])
    );
    assign free_mask[g] = !ent_flags[g].valid || ov_match[g];
  end

  xbuf_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .free_mask (free_mask),
    .advance   (fill_fire),
    .idx_o     (vict_idx)
  );

  xbuf_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .flush_local (flush_local),
    .flush_all   (flush_all),
    .wr_en       (fill_en),
    .wr_idx      (vict_idx),
    .clr_mask    (ov_match),
    .wr_vpn      (fill_vpn),
    .wr_pfn      (fill_pfn),
    .wr_big      (fill_big),
    .wr_glob     (fill_global),
    .touch_en    (lk_hit),
    .touch_idx   (sel_idx),
    .touch_write (lk_write),
    .flags_o     (ent_flags),
    .vpn_o       (ent_vpn),
    .pfn_o       (ent_pfn)
  );

  // Hit select: a small-page match outranks a big-page match.
  always_comb begin
    small_idx   = '0;
    big_idx     = '0;
    small_found = 1'b0;
    big_found   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i] && !ent_flags[i].big && !small_found) begin
        small_idx   = IDX_W'(i);
        small_found = 1'b1;
      end
      if (lk_match[i] && ent_flags[i].big && !big_found) begin
        big_idx   = IDX_W'(i);
        big_found = 1'b1;
      end
    end
    sel_idx   = small_found ? small_idx : big_idx;
    any_match = small_found || big_found;
  end

  always_comb begin
    lk_hit      = lk_req && any_match;
    lk_miss     = lk_req && !any_match;
    lk_paddr    = '0;
    lk_accessed = 1'b0;
    lk_dirty    = 1'b0;
    if (lk_hit) begin
      lk_accessed = ent_flags[sel_idx].acc;
      lk_dirty    = ent_flags[sel_idx].dirty;
      if (ent_flags[sel_idx].big)
        lk_paddr = {ent_pfn[sel_idx][PFN_W-1:BIG_SHIFT], lk_vaddr[BIG_OFS-1:0]};
      else
        lk_paddr = {ent_pfn[sel_idx], lk_vaddr[SMALL_OFS-1:0]};
    end
  end

  // R10: overlap removal on fill keeps every address to a single entry.
  p_single_match_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R4: a request gets exactly one answer.
  p_hit_xor_miss_r4: assert property (@(posedge clk) disable iff (rst)
    lk_req |-> (lk_hit != lk_miss));

  // R4: no request, no answer.
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !lk_req |-> (!lk_hit && !lk_miss));

  // R1: the cycle after reset nothing can hit.
  p_reset_empty_r1: assert property (@(posedge clk)
    $fell(rst) |-> (lk_match == '0));
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_hit, lk_miss, lk_accessed, lk_dirty;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_big = 1'b0;
  logic        fill_global = 1'b0;
  logic        flush_local = 1'b0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_buffer u_xlat_buffer (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .lk_accessed(lk_accessed), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_big(fill_big), .fill_global(fill_global),
    .flush_local(flush_local), .flush_all(flush_all)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Lookup with result sampled in the same cycle; request held over one edge.
  task automatic look(input logic [31:0] va, input logic wr, input logic exp_hit,
                      input logic [31:0] exp_pa, input string tag);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_write = wr;
    #1;
    check(lk_hit == exp_hit, {tag, " hit"}, 32'(lk_hit), 32'(exp_hit));
    check(lk_miss == !exp_hit, {tag, " miss"}, 32'(lk_miss), 32'(!exp_hit));
    if (exp_hit) check(lk_paddr == exp_pa, {tag, " paddr"}, lk_paddr, exp_pa);
    @(negedge clk);
    lk_req = 1'b0; lk_write = 1'b0;
  endtask

  task automatic look_ad(input logic [31:0] va, input logic wr, input logic exp_a,
                         input logic exp_d, input string tag);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_write = wr;
    #1;
    check(lk_hit == 1'b1, {tag, " hit"}, 32'(lk_hit), 32'd1);
    check(lk_accessed == exp_a, {tag, " accessed"}, 32'(lk_accessed), 32'(exp_a));
    check(lk_dirty == exp_d, {tag, " dirty"}, 32'(lk_dirty), 32'(exp_d));
    @(negedge clk);
    lk_req = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic big, input logic glob);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_big = big; fill_global = glob;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic flush(input logic all);
    @(negedge clk);
    if (all) flush_all = 1'b1; else flush_local = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; flush_local = 1'b0;
  endtask

  task automatic t_reset_r1;
    @(negedge clk);
    #1;
    check(!lk_hit && !lk_miss, "R4 idle outputs low", {30'd0, lk_hit, lk_miss}, 32'd0);
    look(32'h0000_0000, 1'b0, 1'b0, '0, "R1 empty after reset addr 0");
    look(32'hFFFF_F123, 1'b0, 1'b0, '0, "R1 empty after reset top addr");
  endtask

  task automatic t_round_robin_r9;
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)
      look({20'h00100 + 20'(i), 12'h0A5}, 1'b0, 1'b1, {20'h00200 + 20'(i), 12'h0A5},
           "R9 free slots all filled");
    fill(20'h001F0, 20'h003F0, 1'b0, 1'b0);
    look({20'h00100, 12'h000}, 1'b0, 1'b0, '0, "R9 rr evicts slot 0");
    look({20'h00101, 12'h004}, 1'b0, 1'b1, {20'h00201, 12'h004}, "R9 slot 1 kept");
    look({20'h001F0, 12'h008}, 1'b0, 1'b1, {20'h003F0, 12'h008}, "R9 new entry present");
    fill(20'h001F1, 20'h003F1, 1'b0, 1'b0);
    look({20'h00101, 12'h000}, 1'b0, 1'b0, '0, "R9 rr evicts slot 1");
    look({20'h00102, 12'h000}, 1'b0, 1'b1, {20'h00202, 12'h000}, "R9 slot 2 kept");
    look({20'h001F0, 12'h000}, 1'b0, 1'b1, {20'h003F0, 12'h000}, "R9 earlier rr fill kept");
    flush(1'b1);
  endtask

  task automatic t_small_r2;
    fill(20'h12345, 20'hABCDE, 1'b0, 1'b0);
    look(32'h1234_5678, 1'b0, 1'b1, 32'hABCD_E678, "R2 small page translate");
    look(32'h1234_5FFF, 1'b0, 1'b1, 32'hABCD_EFFF, "R2 small page last byte");
    look(32'h1234_6000, 1'b0, 1'b0, '0, "R2 next page misses");
  endtask

  task automatic t_fill_timing_r11;
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h0DEAD; fill_pfn = 20'h0BEEF;
    fill_big = 1'b0; fill_global = 1'b0;
    lk_req = 1'b1; lk_vaddr = 32'h0DEA_D010;
    #1;
    check(lk_miss == 1'b1, "R11 fill not visible same cycle", 32'(lk_miss), 32'd1);
    @(negedge clk);
    fill_en = 1'b0;
    #1;
    check(lk_hit == 1'b1, "R11 fill visible after edge", 32'(lk_hit), 32'd1);
    check(lk_paddr == 32'h0BEE_F010, "R11 paddr after fill", lk_paddr, 32'h0BEE_F010);
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic t_big_r3;
    fill(20'h40000, 20'h55400, 1'b1, 1'b0);
    look(32'h4012_3456, 1'b0, 1'b1, 32'h5552_3456, "R3 big page translate");
    look(32'h4000_0000, 1'b0, 1'b1, 32'h5540_0000, "R3 big page first byte");
    look(32'h403F_FFFF, 1'b0, 1'b1, 32'h557F_FFFF, "R3 big page last byte");
    look(32'h4040_0000, 1'b0, 1'b0, '0, "R3 past big region misses");
  endtask

  task automatic t_acc_dirty_r5;
    fill(20'h00077, 20'h00088, 1'b0, 1'b0);
    look_ad(32'h0007_7010, 1'b0, 1'b0, 1'b0, "R5 fresh entry clear");
    look_ad(32'h0007_7010, 1'b0, 1'b1, 1'b0, "R5 read hit sets accessed only");
    look_ad(32'h0007_7020, 1'b1, 1'b1, 1'b0, "R5 before write hit");
    look_ad(32'h0007_7030, 1'b0, 1'b1, 1'b1, "R5 write hit set dirty");
  endtask

  task automatic t_flush_local_r6;
    flush(1'b1);
    fill(20'h0AAAA, 20'h01111, 1'b0, 1'b1);
    fill(20'h0BBBB, 20'h02222, 1'b0, 1'b0);
    fill(20'h80000, 20'h60000, 1'b1, 1'b1);
    flush(1'b0);
    look(32'h0AAA_A004, 1'b0, 1'b1, 32'h0111_1004, "R6 global small kept");
    look(32'h0BBB_B004, 1'b0, 1'b0, '0, "R6 non-global removed");
    look(32'h8000_1234, 1'b0, 1'b1, 32'h6000_1234, "R6 global big kept");
  endtask

  task automatic t_flush_all_r7;
    flush(1'b1);
    look(32'h0AAA_A004, 1'b0, 1'b0, '0, "R7 global small removed");
    look(32'h8000_1234, 1'b0, 1'b0, '0, "R7 global big removed");
  endtask

  task automatic t_flush_prio_r8;
    @(negedge clk);
    flush_all = 1'b1; fill_en = 1'b1; fill_vpn = 20'h0CCCC; fill_pfn = 20'h03333;
    fill_big = 1'b0; fill_global = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; fill_en = 1'b0;
    look(32'h0CCC_C000, 1'b0, 1'b0, '0, "R8 full flush drops fill");
    @(negedge clk);
    flush_local = 1'b1; fill_en = 1'b1; fill_vpn = 20'h0DDDD; fill_pfn = 20'h04444;
    fill_global = 1'b1;
    @(negedge clk);
    flush_local = 1'b0; fill_en = 1'b0;
    look(32'h0DDD_D000, 1'b0, 1'b0, '0, "R8 normal flush drops global fill");
  endtask

  task automatic t_overlap_r10;
    flush(1'b1);
    fill(20'h12345, 20'h11111, 1'b0, 1'b0);
    fill(20'h12345, 20'h22222, 1'b0, 1'b0);
    look(32'h1234_5678, 1'b0, 1'b1, 32'h2222_2678, "R10 refill replaces small");
    fill(20'h12000, 20'h33000, 1'b1, 1'b0);
    look(32'h1234_5678, 1'b0, 1'b1, 32'h3334_5678, "R10 big replaces small");
    fill(20'h12001, 20'h44444, 1'b0, 1'b0);
    look(32'h1200_1ABC, 1'b0, 1'b1, 32'h4444_4ABC, "R10 small replaces big");
    look(32'h1234_5678, 1'b0, 1'b0, '0, "R10 old big removed");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_round_robin_r9();
    t_small_r2();
    t_fill_timing_r11();
    t_big_r3();
    t_acc_dirty_r5();
    t_flush_local_r6();
    t_flush_all_r7();
    t_flush_prio_r8();
    t_overlap_r10();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule